// File: doc/BRIEF.md
# Reset-Gated OR Multiplexer

This block is a registered N-to-1 selector for wide datapaths. Each source bus feeds its own register bank. On every enabled clock edge only the bank addressed by the binary select loads its bus. Every other bank is cleared through its synchronous clear. The result is the bitwise OR of all bank outputs. Because at most one bank holds a non-zero word, that OR equals the bank that loaded, so no decoding mux stands after the registers. The selection is seen one cycle after the edge that sampled the select.

Beside the selector sits a small constant register. It has per-bit synchronous set and clear controls that may be driven together, and clear takes priority. Driving a chosen pattern on the set inputs and its complement on the clear inputs places any fixed word in that register. A global enable freezes both parts. A synchronous reset zeroes both parts and takes priority over the enable.

Top module: `orsel_mux`

## Requirements
- R1: On an edge with `en` high and `sel` below `N_SRC`, the addressed bank loads its bus, and `mux_q` shows that bus from the following cycle.
- R2: On an edge with `en` high, every bank that `sel` does not address is cleared to zero, so a word loaded earlier never reappears at `mux_q` after another source is chosen.
- R3: `mux_q` is the bitwise OR of all banks. At most one bank is non-zero, so `mux_q` carries exactly the chosen bus, with no bits from other sources.
- R4: An enabled edge with `sel` at or above `N_SRC` clears every bank, and `mux_q` reads zero afterwards.
- R5: With `en` low, all banks and the constant register keep their contents, whatever `sel`, `src_bus`, `k_set` and `k_clr` carry, and both outputs stay unchanged.
- R6: On an enabled edge, a bit of `k_q` whose `k_clr` bit is 1 becomes 0, even if its `k_set` bit is also 1.
- R7: On an enabled edge, a bit with `k_set` 1 and `k_clr` 0 becomes 1, and a bit with both at 0 keeps its value. Setting `k_set` to W and `k_clr` to ~W therefore loads the word W.
- R8: `srst` high at an edge zeroes every bank and the constant register, whatever `en` is.
- R9: `N_SRC` may be any value from 2 upward. The default is 4, and 8 is supported. Source i occupies bits [i*WIDTH +: WIDTH] of `src_bus`. `sel` is $clog2(N_SRC) bits wide and is read as an unsigned index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable for all registers |
| sel | input | SEL_W ($clog2(N_SRC)) | Binary index of the source to capture |
| src_bus | input | N_SRC*WIDTH | Packed source buses, source i at [i*WIDTH +: WIDTH] |
| k_set | input | WIDTH | Per-bit synchronous set for the constant register |
| k_clr | input | WIDTH | Per-bit synchronous clear for the constant register, wins over set |
| mux_q | output | WIDTH | OR of all bank outputs |
| k_q | output | WIDTH | Constant register contents |

## Verification
Two functions can act on the same edge: the bank selection update and the set/clear update of the constant register. Both share one enable and one reset. The sweep drives a new select, fresh source data and new set/clear patterns together on every cycle, with and without the enable, and with reset raised in the middle of enabled traffic. Each output is judged against its own arithmetic model. The model shifts and masks the packed bus for the selector and computes (old | set) & ~clr for the constant. A fault in the shared enable or reset gating therefore shows in one output even while the other is still correct.

// File: rtl/orsel_pkg.sv
package orsel_pkg;
   // width of a binary index able to address n items (at least one bit)
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/orsel_decode.sv
module orsel_decode #(
   parameter int N_SRC = 4,
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0] sel,
   output logic [N_SRC-1:0] hit
);
   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_hit
         if (i < (1 << SEL_W)) begin : g_reach
            assign hit[i] = (sel == SEL_W'(i));
         end else begin : g_unreach
            assign hit[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/orsel_bank.sv
module orsel_bank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             en,
   input  logic             hit,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   // clear dominates: reset, or enabled edge for an unaddressed bank
   always_ff @(posedge clk) begin
      if (srst || (en && !hit)) q <= '0;
      else if (en)              q <= d;
   end

   p_load_r1: assert property (@(posedge clk) disable iff (srst)
      (en && hit) |=> (q == $past(d)));
   p_unsel_clear_r2: assert property (@(posedge clk) disable iff (srst)
      (en && !hit) |=> (q == '0));
   p_hold_r5: assert property (@(posedge clk) disable iff (srst)
      !en |=> $stable(q));
endmodule

// File: rtl/orsel_merge.sv
module orsel_merge #(
   parameter int N_SRC = 4,
   parameter int WIDTH = 8
) (
   input  logic [N_SRC*WIDTH-1:0] banks,
   output logic [WIDTH-1:0]       merged
);
   logic [WIDTH-1:0] acc [N_SRC];

   assign acc[0] = banks[WIDTH-1:0];
   generate
      for (genvar i = 1; i < N_SRC; i++) begin : g_or
         assign acc[i] = acc[i-1] | banks[i*WIDTH +: WIDTH];
      end
   endgenerate
   assign merged = acc[N_SRC-1];
endmodule

// File: rtl/orsel_const.sv
module orsel_const #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             en,
   input  logic [WIDTH-1:0] set_bits,
   input  logic [WIDTH-1:0] clr_bits,
   output logic [WIDTH-1:0] q
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         always_ff @(posedge clk) begin
            if (srst)             q[b] <= 1'b0;
            else if (en) begin
               if (clr_bits[b])      q[b] <= 1'b0;
               else if (set_bits[b]) q[b] <= 1'b1;
            end
         end
      end
   endgenerate

   p_clr_wins_r6: assert property (@(posedge clk) disable iff (srst)
      en |=> ((q & $past(clr_bits)) == '0));
   p_set_ones_r7: assert property (@(posedge clk) disable iff (srst)
      en |=> ((q & ($past(set_bits) & ~$past(clr_bits)))
              == ($past(set_bits) & ~$past(clr_bits))));
   p_hold_bits_r7: assert property (@(posedge clk) disable iff (srst)
      en |=> ((q & ~($past(set_bits) | $past(clr_bits)))
              == ($past(q) & ~($past(set_bits) | $past(clr_bits)))));
   p_const_hold_r5: assert property (@(posedge clk) disable iff (srst)
      !en |=> $stable(q));
endmodule

// File: rtl/orsel_mux.sv
module orsel_mux
   import orsel_pkg::*;
#(
   parameter int N_SRC = 4,
   parameter int WIDTH = 8,
   localparam int SEL_W = idx_width(N_SRC)
) (
   input  logic                   clk,
   input  logic                   srst,
   input  logic                   en,
   input  logic [SEL_W-1:0]       sel,
   input  logic [N_SRC*WIDTH-1:0] src_bus,
   input  logic [WIDTH-1:0]       k_set,
   input  logic [WIDTH-1:0]       k_clr,
   output logic [WIDTH-1:0]       mux_q,
   output logic [WIDTH-1:0]       k_q
);
   // elaboration-time parameter checks (R9)
   generate
      if (N_SRC < 2) begin : g_bad_nsrc
         $error("orsel_mux: N_SRC must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("orsel_mux: WIDTH must be at least 1");
      end
   endgenerate

   logic [N_SRC-1:0]       hit;
   logic [N_SRC*WIDTH-1:0] bank_q;
   logic [N_SRC-1:0]       bank_nz;

   orsel_decode #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_dec (
      .sel (sel),
      .hit (hit)
   );

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_bank
         orsel_bank #(.WIDTH(WIDTH)) u_bank (
            .clk  (clk),
            .srst (srst),
            .en   (en),
            .hit  (hit[i]),
            .d    (src_bus[i*WIDTH +: WIDTH]),
            .q    (bank_q[i*WIDTH +: WIDTH])
         );
         assign bank_nz[i] = |bank_q[i*WIDTH +: WIDTH];
      end
   endgenerate

   orsel_merge #(.N_SRC(N_SRC), .WIDTH(WIDTH)) u_merge (
      .banks  (bank_q),
      .merged (mux_q)
   );

   orsel_const #(.WIDTH(WIDTH)) u_const (
      .clk      (clk),
      .srst     (srst),
      .en       (en),
      .set_bits (k_set),
      .clr_bits (k_clr),
      .q        (k_q)
   );

   p_single_bank_r3: assert property (@(posedge clk) disable iff (srst)
      $onehot0(bank_nz));
   p_oor_zero_r4: assert property (@(posedge clk) disable iff (srst)
      (en && (int'(sel) >= N_SRC)) |=> (mux_q == '0));
   p_out_follows_r1: assert property (@(posedge clk) disable iff (srst)
      (en && (int'(sel) < N_SRC)) |=>
      (mux_q == $past(src_bus[int'(sel)*WIDTH +: WIDTH])));
   p_reset_zero_r8: assert property (@(posedge clk)
      srst |=> ((mux_q == '0) && (k_q == '0)));
endmodule

// File: tb/test_orsel_mux.sv
module test_orsel_mux;
   localparam int N  = 6;
   localparam int W  = 4;
   localparam int N8 = 8;

   logic           clk = 1'b0;
   logic           srst, en;
   logic [2:0]     sel, sel8;
   logic [N*W-1:0] src;
   logic [N8*W-1:0] src8;
   logic [W-1:0]   kset, kclr;
   logic [W-1:0]   mux_q, k_q, mux8_q, k8_q;
   logic [W-1:0]   m_out, m_k, m8_out;
   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   orsel_mux #(.N_SRC(N), .WIDTH(W)) i_orsel_mux (
      .clk(clk), .srst(srst), .en(en), .sel(sel), .src_bus(src),
      .k_set(kset), .k_clr(kclr), .mux_q(mux_q), .k_q(k_q));

   orsel_mux #(.N_SRC(N8), .WIDTH(W)) i_orsel_mux_n8 (
      .clk(clk), .srst(srst), .en(en), .sel(sel8), .src_bus(src8),
      .k_set('0), .k_clr('0), .mux_q(mux8_q), .k_q(k8_q));

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one edge: advance the models from the driven inputs, then sample at negedge
   task automatic cyc();
      @(posedge clk);
      if (srst) begin
         m_out = '0; m_k = '0; m8_out = '0;
      end else if (en) begin
         m_out  = (int'(sel) < N) ? W'(src >> (int'(sel) * W)) : '0;
         m_k    = (m_k | kset) & ~kclr;
         m8_out = W'(src8 >> (int'(sel8) * W));
      end
      @(negedge clk);
   endtask

   task automatic put_field(input int i, input logic [W-1:0] v);
      src[i*W +: W] = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
      $finish;
   end

   initial begin
      srst = 1'b1; en = 1'b1; sel = '0; sel8 = '0;
      src = '1; src8 = '1; kset = '1; kclr = '0;
      m_out = '0; m_k = '0; m8_out = '0;
      @(negedge clk);
      repeat (3) cyc();
      chk("R8 reset mux_q", mux_q, '0);
      chk("R8 reset k_q", k_q, '0);
      srst = 1'b0;

      // selector and constant updates on the same edges
      for (int s = 0; s < 8; s++) begin
         for (int r = 0; r < 12; r++) begin
            sel = 3'(s); src = N*W'($urandom); kset = W'($urandom); kclr = W'($urandom);
            en = 1'b1;
            cyc();
            chk((s < N) ? "R1 select" : "R4 out of range", mux_q, m_out);
            chk("R6 constant update", k_q, m_k);
         end
      end

      // no leak of an earlier bank after reselect (R2) or OR pollution (R3)
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            if (a != b) begin
               sel = 3'(a); src = N*W'($urandom); put_field(a, '1);
               cyc();
               chk("R1 load ones", mux_q, '1);
               sel = 3'(b); src = '1; put_field(b, '0);
               cyc();
               chk("R2 stale bank cleared", mux_q, 4'h0);
               sel = 3'(a); src = '1;
               cyc();
               sel = 3'(b); src = '1; put_field(b, 4'(a * 3 + b));
               cyc();
               chk("R3 exact chosen bus", mux_q, 4'(a * 3 + b));
            end
         end
      end

      // enable low: everything frozen
      sel = 3'd2; src = N*W'(24'h5A3C96); kset = 4'b1010; kclr = 4'b0001; en = 1'b1;
      cyc();
      for (int r = 0; r < 40; r++) begin
         en = 1'b0; sel = 3'($urandom); src = N*W'($urandom);
         kset = W'($urandom); kclr = W'($urandom);
         cyc();
         chk("R5 hold mux_q", mux_q, m_out);
         chk("R5 hold k_q", k_q, m_k);
      end
      en = 1'b1;

      // constant register: every set/clear combination
      for (int s = 0; s < 16; s++) begin
         for (int c = 0; c < 16; c++) begin
            kset = 4'(s); kclr = 4'(c);
            cyc();
            chk(((s & c) != 0) ? "R6 clear wins" : "R7 set or hold", k_q, m_k);
         end
      end
      for (int w = 0; w < 16; w++) begin
         kset = 4'(w); kclr = ~4'(w);
         cyc();
         chk("R7 arbitrary word", k_q, 4'(w));
      end

      // reset during enabled traffic
      sel = 3'd1; src = '1; kset = '1; kclr = '0;
      cyc();
      srst = 1'b1;
      cyc();
      chk("R8 mid-run mux_q", mux_q, '0);
      chk("R8 mid-run k_q", k_q, '0);
      srst = 1'b0;

      // eight-source configuration
      for (int s = 0; s < N8; s++) begin
         for (int r = 0; r < 6; r++) begin
            sel8 = 3'(s); src8 = N8*W'($urandom);
            cyc();
            chk("R9 eight sources", mux8_q, m8_out);
         end
      end
      chk("R9 eight-source constant idle", k8_q, '0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
      $finish;
   end
endmodule